// File: doc/BRIEF.md
# Three-Carrier Shoot-Through PWM Modulator

This block is the gate-pattern generator for a three-phase, two-level inverter with a boost switch ahead of its DC link. Three triangle carriers are built from one phase counter. One carrier drives the inverter comparisons. The other two run one sixth and two sixths of a period ahead of it and drive the boost switch. The three phase references are centred by a min/max offset and then compared with the inverter carrier. A shoot-through interval at each peak and each valley of the inverter carrier turns on all six inverter switches. The booster carriers place four boost-charging intervals per period in the gaps between these shoot-through intervals.

The carrier period is set by a step value S, given in clock cycles. The carrier peak is P = 3·S and a full period lasts 6·S cycles, so the 60-degree shift is exact for every S. References are signed counts relative to the carrier mid-point. The shoot-through duty d is an unsigned count compared against the carrier. Step, references and duty are captured only at the inverter-carrier valley, and also on every cycle while the block is disabled. A period therefore always runs on one consistent set of values.

Top module: `qsb_carrier_pwm`

## Requirements
- R1: While reset is active, all seven gate outputs are low. When the enable input is low at a rising clock edge, all seven gate outputs are low from that edge on.
- R2: The inverter carrier counts from 0 up to P = 3·S and back down, one count per cycle, over 6·S cycles. After the enable input rises, the first enabled cycle sits at the carrier valley (value 0).
- R3: Each reference is shifted by floor(P/2) − floor((max+min)/2), where max and min are taken over the three references. The result is clamped to [0, P]. Outside shoot-through, the upper gate of a phase is high exactly when its shifted reference is strictly greater than the inverter carrier, and the lower gate is its complement.
- R4: While the inverter carrier is below d or above P − d, all six inverter gates are high. For d ≥ 1 this gives 4·d − 2 shoot-through cycles per period, in two separate intervals.
- R5: The booster carriers run ahead of the inverter carrier by S and by 2·S counts. The boost gate is high when either booster carrier is below d or above P − d and no shoot-through is active. For 1 ≤ d and 2·d − 1 < S, this gives 8·d − 4 boost cycles per period, which is twice the shoot-through time, in four separate intervals.
- R6: The boost gate is never high in a cycle where inverter shoot-through is active.
- R7: With d = 0, no shoot-through and no boost interval occur, and each phase's upper and lower gates are always complementary.
- R8: A change of step, duty or references in the middle of a period has no effect until the inverter carrier returns to its valley.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enIn | input | 1 | Synchronous run enable |
| stepIn | input | STEP_W | Step S; peak P = 3·S, period 6·S cycles |
| refA | input | REF_W | Phase A reference, signed, relative to the carrier mid-point |
| refB | input | REF_W | Phase B reference, signed |
| refC | input | REF_W | Phase C reference, signed |
| dutyIn | input | CNT_W | Shoot-through duty d in carrier counts |
| gHi | output | 3 | Upper gates, bit 0 = phase A, bit 1 = phase B, bit 2 = phase C |
| gLo | output | 3 | Lower gates, same bit order as gHi |
| gBoost | output | 1 | Boost-switch gate |

## Verification
The bench runs a cycle-accurate model alongside the design and also counts cycles and intervals over whole periods. A design with a wrong carrier phase shift would let boost intervals overlap shoot-through, or would merge them, so the interval counts of four and two would drop. An off-by-one in a threshold comparison would show up as 4·d and 8·d cycles instead of 4·d − 2 and 8·d − 4. References far outside the carrier range check the clamping: an unclamped design would wrap and hold a gate high or low for the wrong share of the period. Duty and step values written in mid-period, and an enable toggled in mid-period, expose a design that captures its inputs too early or restarts the carriers out of phase.

// File: rtl/qsb_pwm_pkg.sv
package qsb_pwm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture new references and duty
    logic run;   // gates may be driven
  } pwm_strobe_t;
endpackage

// File: rtl/qsb_pwm_ctrl.sv
module qsb_pwm_ctrl
  import qsb_pwm_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int CNT_W  = STEP_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic [STEP_W-1:0] stepIn,
  output pwm_strobe_t       strb,
  output logic [CNT_W-1:0]  phase,
  output logic [STEP_W-1:0] stepQ
);
  logic              runQ;
  logic [CNT_W-1:0]  fullCnt;
  logic [CNT_W-1:0]  lastPh;
  logic              atLast;

  assign fullCnt = (CNT_W'(stepQ) << 2) + (CNT_W'(stepQ) << 1);
  assign lastPh  = fullCnt - CNT_W'(1);
  assign atLast  = runQ && (phase == lastPh);

  assign strb.load = !enIn || atLast;
  assign strb.run  = runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      phase <= '0;
      stepQ <= '0;
    end else begin
      if (!enIn) begin
        runQ  <= 1'b0;
        phase <= '0;
      end else begin
        runQ <= 1'b1;
        if (runQ) phase <= atLast ? '0 : phase + CNT_W'(1);
      end
      if (strb.load) stepQ <= stepIn;
    end
  end

  // R2: the counter stays inside one carrier period
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> (phase <= lastPh));
  // R2: the first enabled cycle sits at the carrier valley
  a_r2_restart_valley: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> (phase == '0));
  // R8: the step changes only on a load strobe
  a_r8_step_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(stepQ));
endmodule

// File: rtl/qsb_pwm_dp.sv
module qsb_pwm_dp
  import qsb_pwm_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int CNT_W  = STEP_W + 3,
  parameter int REF_W  = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pwm_strobe_t             strb,
  input  logic [CNT_W-1:0]        phase,
  input  logic [STEP_W-1:0]       stepQ,
  input  logic signed [REF_W-1:0] refA,
  input  logic signed [REF_W-1:0] refB,
  input  logic signed [REF_W-1:0] refC,
  input  logic [CNT_W-1:0]        dutyIn,
  output logic [2:0]              gHi,
  output logic [2:0]              gLo,
  output logic                    gBoost
);
  localparam int WW = REF_W + 3;
  localparam int NCAR = 3;

  logic signed [REF_W-1:0] refQ [3];
  logic [CNT_W-1:0]        dutyQ;
  logic [CNT_W-1:0]        peak;
  logic [CNT_W:0]          full;
  logic [CNT_W-1:0]        carr [NCAR];
  logic [NCAR-1:0]         nearEdge;
  logic                    shootThru;
  logic                    boostReq;
  logic [2:0]              cmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ[0] <= '0;
      refQ[1] <= '0;
      refQ[2] <= '0;
      dutyQ   <= '0;
    end else if (strb.load) begin
      refQ[0] <= refA;
      refQ[1] <= refB;
      refQ[2] <= refC;
      dutyQ   <= dutyIn;
    end
  end

  assign peak = (CNT_W'(stepQ) << 1) + CNT_W'(stepQ);
  assign full = {peak, 1'b0};

  // carrier 0 drives the inverter, carriers 1 and 2 lead by S and 2S
  for (genvar k = 0; k < NCAR; k++) begin : g_car
    logic [CNT_W:0] pSum;
    logic [CNT_W:0] pWrap;
    assign pSum  = {1'b0, phase} + (CNT_W+1)'(stepQ) * (CNT_W+1)'(k);
    assign pWrap = (pSum >= full) ? pSum - full : pSum;
    assign carr[k] = (pWrap <= {1'b0, peak}) ? pWrap[CNT_W-1:0]
                                             : CNT_W'(full - pWrap);
    assign nearEdge[k] = (carr[k] < dutyQ) ||
                         (({1'b0, carr[k]} + {1'b0, dutyQ}) > {1'b0, peak});
  end

  assign shootThru = nearEdge[0];
  assign boostReq  = (nearEdge[1] || nearEdge[2]) && !shootThru;

  // min/max centring of the references
  logic signed [WW-1:0] maxR, minR, halfMm, offV;
  always_comb begin
    maxR = WW'(refQ[0]);
    minR = WW'(refQ[0]);
    for (int i = 1; i < 3; i++) begin
      if (WW'(refQ[i]) > maxR) maxR = WW'(refQ[i]);
      if (WW'(refQ[i]) < minR) minR = WW'(refQ[i]);
    end
    halfMm = (maxR + minR) >>> 1;
    offV   = $signed({{(WW-CNT_W){1'b0}}, peak >> 1}) - halfMm;
  end

  for (genvar i = 0; i < 3; i++) begin : g_ph
    logic signed [WW-1:0] modS;
    logic [CNT_W-1:0]     modU;
    assign modS = WW'(refQ[i]) + offV;
    always_comb begin
      if (modS < 0) modU = '0;
      else if (modS > $signed({{(WW-CNT_W){1'b0}}, peak})) modU = peak;
      else modU = modS[CNT_W-1:0];
    end
    assign cmp[i] = modU > carr[0];
  end

  assign gHi    = strb.run ? (cmp | {3{shootThru}})  : 3'b000;
  assign gLo    = strb.run ? (~cmp | {3{shootThru}}) : 3'b000;
  assign gBoost = strb.run && boostReq;

  // R8: captured values hold between load strobes
  a_r8_refs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(dutyQ) && $stable(refQ[0]) && $stable(refQ[1]) && $stable(refQ[2])));
  // R7: zero duty keeps every leg complementary while running
  a_r7_complementary: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && dutyQ == '0) |-> ((gHi ^ gLo) == 3'b111));
  // R6: boost gate never coincides with a shorted leg
  a_r6_boost_excl: assert property (@(posedge clk) disable iff (!rstN)
    gBoost |-> !(gHi[0] && gLo[0]));
endmodule

// File: rtl/qsb_carrier_pwm.sv
module qsb_carrier_pwm
  import qsb_pwm_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int CNT_W  = STEP_W + 3,
  parameter int REF_W  = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enIn,
  input  logic [STEP_W-1:0]       stepIn,
  input  logic signed [REF_W-1:0] refA,
  input  logic signed [REF_W-1:0] refB,
  input  logic signed [REF_W-1:0] refC,
  input  logic [CNT_W-1:0]        dutyIn,
  output logic [2:0]              gHi,
  output logic [2:0]              gLo,
  output logic                    gBoost
);
  pwm_strobe_t       strb;
  logic [CNT_W-1:0]  phase;
  logic [STEP_W-1:0] stepQ;

  qsb_pwm_ctrl #(.STEP_W(STEP_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enIn(enIn), .stepIn(stepIn),
    .strb(strb), .phase(phase), .stepQ(stepQ)
  );

  qsb_pwm_dp #(.STEP_W(STEP_W), .CNT_W(CNT_W), .REF_W(REF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .phase(phase), .stepQ(stepQ),
    .refA(refA), .refB(refB), .refC(refC), .dutyIn(dutyIn),
    .gHi(gHi), .gLo(gLo), .gBoost(gBoost)
  );

  // R1: a low enable at an edge silences every gate from that edge
  a_r1_disable_low: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> (gHi == 3'b000 && gLo == 3'b000 && !gBoost));
endmodule

// File: tb/qsb_carrier_pwm_tb.sv
module qsb_carrier_pwm_tb_top;
  localparam int STEP_W = 8;
  localparam int CNT_W  = STEP_W + 3;
  localparam int REF_W  = CNT_W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b0;
  logic [STEP_W-1:0] stepIn = 8'd10;
  logic signed [REF_W-1:0] refA = '0, refB = '0, refC = '0;
  logic [CNT_W-1:0] dutyIn = '0;
  logic [2:0] gHi, gLo;
  logic gBoost;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  qsb_carrier_pwm #(.STEP_W(STEP_W), .CNT_W(CNT_W), .REF_W(REF_W)) dut_i (
    .clk(clk), .rstN(rstN), .enIn(enIn), .stepIn(stepIn),
    .refA(refA), .refB(refB), .refC(refC), .dutyIn(dutyIn),
    .gHi(gHi), .gLo(gLo), .gBoost(gBoost)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model built from the requirements ----------
  int mRun = 0, mPh = 0, mS = 0, mD = 0;
  int mR [3] = '{0, 0, 0};

  function automatic int triOf(input int p, input int s);
    int full = 6 * s;
    int pw = p % full;
    return (pw <= 3 * s) ? pw : full - pw;
  endfunction

  function automatic int nearOf(input int t, input int d, input int pk);
    return ((t < d) || (t > pk - d)) ? 1 : 0;
  endfunction

  function automatic logic [6:0] expGates();
    int pk, t0, st, b, half, mx, mn, m;
    logic [2:0] hi, lo;
    if (mRun == 0) return 7'd0;
    pk = 3 * mS;
    t0 = triOf(mPh, mS);
    st = nearOf(t0, mD, pk);
    b  = nearOf(triOf(mPh + mS, mS), mD, pk) | nearOf(triOf(mPh + 2 * mS, mS), mD, pk);
    mx = mR[0]; mn = mR[0];
    for (int i = 1; i < 3; i++) begin
      if (mR[i] > mx) mx = mR[i];
      if (mR[i] < mn) mn = mR[i];
    end
    half = (mx + mn) >>> 1;
    for (int i = 0; i < 3; i++) begin
      m = mR[i] + pk / 2 - half;
      if (m < 0) m = 0;
      if (m > pk) m = pk;
      hi[i] = (m > t0) || (st != 0);
      lo[i] = (m <= t0) || (st != 0);
    end
    return {(st == 0) && (b != 0), lo, hi};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mPh = 0; mS = 0; mD = 0; mR = '{0, 0, 0};
    end else begin
      bit ld;
      ld = !enIn || (mRun != 0 && mPh == 6 * mS - 1);
      if (!enIn) begin
        mRun = 0; mPh = 0;
      end else begin
        if (mRun != 0) mPh = (mPh == 6 * mS - 1) ? 0 : mPh + 1;
        mRun = 1;
      end
      if (ld) begin
        mS = int'(stepIn); mD = int'(dutyIn);
        mR = '{int'(refA), int'(refB), int'(refC)};
      end
    end
  end

  // per-cycle comparison against the model (R3 R4 R5 R8)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [6:0] e;
      e = expGates();
      check({gBoost, gLo, gHi} == e, "R3/R4/R5/R8 gate pattern", int'({gBoost, gLo, gHi}), int'(e));
    end
  end

  // ---------------- helpers ----------------
  task automatic restart();
    @(negedge clk) enIn = 1'b0;
    @(negedge clk) enIn = 1'b1;
    @(negedge clk);  // now at the first enabled cycle, phase 0
  endtask

  // sample one full period starting at the current negedge
  task automatic periodStats(input int s, output int stCnt, output int bCnt,
                             output int stRise, output int bRise, output int overlap);
    bit stA [256];
    bit bA [256];
    int n = 6 * s;
    stCnt = 0; bCnt = 0; stRise = 0; bRise = 0; overlap = 0;
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      stA[i] = (gHi[0] && gLo[0]);
      bA[i]  = gBoost;
      if (stA[i]) stCnt++;
      if (bA[i]) bCnt++;
      if (stA[i] && bA[i]) overlap++;
    end
    for (int i = 0; i < n; i++) begin
      if (stA[i] && !stA[(i + n - 1) % n]) stRise++;
      if (bA[i] && !bA[(i + n - 1) % n]) bRise++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (2) @(negedge clk);
    check({gBoost, gLo, gHi} == 7'd0, "R1 reset gates", int'({gBoost, gLo, gHi}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({gBoost, gLo, gHi} == 7'd0, "R1 disabled after reset", int'({gBoost, gLo, gHi}), 0);
  endtask

  task automatic t_zero_duty();
    int st, b, sr, br, ov;
    stepIn = 8'd10; dutyIn = '0; refA = 12; refB = -7; refC = -3;
    restart();
    periodStats(10, st, b, sr, br, ov);
    check(st == 0, "R7 no shoot-through at d=0", st, 0);
    check(b == 0, "R7 no boost at d=0", b, 0);
  endtask

  task automatic t_intervals();
    int st, b, sr, br, ov;
    stepIn = 8'd12; dutyIn = 11'd3; refA = 5; refB = -5; refC = 0;
    restart();
    periodStats(12, st, b, sr, br, ov);
    check(st == 10, "R4 shoot-through cycles", st, 10);
    check(sr == 2, "R4 shoot-through intervals", sr, 2);
    check(b == 20, "R5 boost cycles twice shoot-through", b, 20);
    check(br == 4, "R5 boost intervals", br, 4);
    check(ov == 0, "R6 boost during shoot-through", ov, 0);
  endtask

  task automatic t_wide_duty();
    int st, b, sr, br, ov;
    stepIn = 8'd6; dutyIn = 11'd9; refA = 0; refB = 0; refC = 0;
    restart();
    periodStats(6, st, b, sr, br, ov);
    check(ov == 0, "R6 boost masked by wide shoot-through", ov, 0);
  endtask

  task automatic t_offset();
    int cntHi [3];
    stepIn = 8'd20; dutyIn = '0; refA = 40; refB = -20; refC = -30;
    restart();
    cntHi = '{0, 0, 0};
    for (int i = 0; i < 120; i++) begin
      if (i != 0) @(negedge clk);
      for (int j = 0; j < 3; j++) if (gHi[j]) cntHi[j]++;
    end
    // shifted refs: A clamps to P=60, B=5, C clamps to 0
    check(cntHi[0] == 119, "R3 phase A clamped high", cntHi[0], 119);
    check(cntHi[1] == 9, "R3 phase B centred", cntHi[1], 9);
    check(cntHi[2] == 0, "R3 phase C clamped low", cntHi[2], 0);
  endtask

  task automatic t_latch();
    int st, b, sr, br, ov, stLate;
    stepIn = 8'd10; dutyIn = '0; refA = 0; refB = 0; refC = 0;
    restart();
    for (int i = 1; i < 15; i++) @(negedge clk);
    dutyIn = 11'd4; stepIn = 8'd8;
    stLate = 0;
    for (int i = 15; i < 60; i++) begin
      @(negedge clk);
      if (gHi[0] && gLo[0]) stLate++;
    end
    check(stLate == 0, "R8 mid-period duty ignored", stLate, 0);
    @(negedge clk);
    periodStats(8, st, b, sr, br, ov);
    check(st == 14, "R8 new duty and step after valley", st, 14);
  endtask

  task automatic t_restart();
    stepIn = 8'd8; dutyIn = 11'd2; refA = 3; refB = 0; refC = -3;
    restart();
    repeat (20) @(negedge clk);
    enIn = 1'b0;
    @(negedge clk);
    check({gBoost, gLo, gHi} == 7'd0, "R1 disable mid-period", int'({gBoost, gLo, gHi}), 0);
    repeat (3) @(negedge clk);
    enIn = 1'b1;
    @(negedge clk);
    check({gBoost, gLo, gHi} == 7'b0111111, "R2 restart at valley", int'({gBoost, gLo, gHi}), 63);
    @(negedge clk);
    check(gHi == 3'b111 && gLo == 3'b111, "R2 second cycle still shorted", int'({gLo, gHi}), 63);
    @(negedge clk);
    check((gHi ^ gLo) == 3'b111, "R2 carrier leaves valley", int'(gHi ^ gLo), 7);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero_duty();
    t_intervals();
    t_wide_duty();
    t_offset();
    t_latch();
    t_restart();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule